// File: doc/BRIEF.md
# Instruction Field Decoder

This block takes one 32-bit instruction word of a small load/store RISC subset and turns it, in the same cycle, into the signals that the rest of a core needs. It splits the word into register-format, immediate-format or jump-format fields. It then drives the two read indices, the destination index with its write enable, an ALU operation code, an extended 32-bit immediate, memory read and write strobes, branch-on-equal, branch-on-not-equal and jump flags, and an illegal-instruction flag.

The block is purely combinational. A small control table decodes the opcode and function code into a bundle of strobes. A datapath stage slices the fields, extends the immediate by instruction class and gates the write port. The supported operations are add, sub, and, or, slt, sll, srl, addi, slti, andi, ori, lui, lw, sw, beq, bne and j. Every other encoding is reported as illegal, and every side effect is held off for it.

Top module: `instr_decoder`

## Requirements
- R1: The read index `rsIdx` is bits 25:21 and `rtIdx` is bits 20:16 of the word. `shiftAmt` is bits 10:6 and `jumpTarget` is bits 25:0. The opcode is bits 31:26 and the function code is bits 5:0.
- R2: When opcode 0x00 carries a listed function code, `aluOp` selects the operation as follows: 0x20 gives ADD(0), 0x22 gives SUB(1), 0x24 gives AND(2), 0x25 gives OR(3), 0x2A gives SLT(4), 0x00 gives SLL(5) and 0x02 gives SRL(6).
- R3: Register-format operations select rd (bits 15:11) as `wrIdx`. Opcodes 0x08, 0x0A, 0x0C, 0x0D, 0x0F and 0x23 select rt as `wrIdx`. `regWrEn` is 1 for all of these, unless R4 applies.
- R4: When the selected destination index is 0, `regWrEn` is 0.
- R5: Opcodes 0x08 (addi), 0x0A (slti), 0x23 (lw), 0x2B (sw), 0x04 (beq) and 0x05 (bne) sign-extend bits 15:0 into `immValue`.
- R6: Opcodes 0x0C (andi) and 0x0D (ori) zero-extend bits 15:0 into `immValue`.
- R7: Opcode 0x0F (lui) puts bits 15:0 into `immValue[31:16]`, clears `immValue[15:0]` and sets `aluOp` to PASSB(7).
- R8: Opcode 0x23 raises `memRead`. Opcode 0x2B raises `memWrite` and does not write a register. Both use `aluOp` ADD(0). At most one of `memRead`, `memWrite`, `branchEq`, `branchNe` and `jump` is high at any time.
- R9: Opcode 0x04 raises `branchEq` and opcode 0x05 raises `branchNe`. Both use `aluOp` SUB(1) and write no register.
- R10: Opcode 0x02 raises `jump`. It writes no register and raises no memory strobe.
- R11: Any unlisted opcode, or opcode 0x00 with an unlisted function code, raises `illegal`. It forces `regWrEn`, `memRead`, `memWrite`, `branchEq`, `branchNe` and `jump` to 0.
- R12: `immValue` is 0 for register-format operations, for jumps and for illegal words. `wrIdx` is 0 whenever the operation writes no register. `aluOp` is ADD(0) for jumps and illegal words.
- R13: The immediate ALU opcodes select `aluOp` as follows: 0x08 gives ADD(0), 0x0A gives SLT(4), 0x0C gives AND(2) and 0x0D gives OR(3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| rsIdx | output | 5 | First register read index |
| rtIdx | output | 5 | Second register read index |
| shiftAmt | output | 5 | Shift amount field |
| jumpTarget | output | 26 | Jump target field |
| wrIdx | output | 5 | Destination register index |
| regWrEn | output | 1 | Register write enable |
| aluOp | output | 4 | ALU operation code |
| immValue | output | 32 | Extended immediate |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| branchEq | output | 1 | Branch if operands are equal |
| branchNe | output | 1 | Branch if operands differ |
| jump | output | 1 | Unconditional jump |
| illegal | output | 1 | Unrecognised encoding |

## Verification
Every output is a combinational function of `instrWord`, so each result is due in the same cycle as the word that produces it, with zero register stages. The bench changes the word one time unit after a rising edge and samples two time units later, well before the next edge. Each sample then sees only the word applied in that cycle. The sweep covers all 64 opcodes, and all 64 function codes under opcode 0. Each code is tried with several operand-field patterns, including a zero destination and a negative immediate.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_W   = 5;
  localparam int FUNCT_W = 6;
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;
  localparam int TGT_W   = INSTR_W - OPC_W;
  localparam int ALU_W   = 4;

  localparam int RS_LSB = TGT_W - REG_W;
  localparam int RT_LSB = RS_LSB - REG_W;
  localparam int RD_LSB = RT_LSB - REG_W;
  localparam int SH_LSB = RD_LSB - SHAMT_W;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD   = 4'd0,
    ALU_SUB   = 4'd1,
    ALU_AND   = 4'd2,
    ALU_OR    = 4'd3,
    ALU_SLT   = 4'd4,
    ALU_SLL   = 4'd5,
    ALU_SRL   = 4'd6,
    ALU_PASSB = 4'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_SIGN, IMM_ZERO, IMM_UPPER
  } immKind_e;

  typedef struct packed {
    logic     regWrite;
    logic     dstRd;
    logic     memRd;
    logic     memWr;
    logic     brEq;
    logic     brNe;
    logic     jmp;
    logic     illegal;
    immKind_e immKind;
    aluOp_e   aluOp;
  } ctrlStrobes_t;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI  = 6'h0F;
  localparam logic [OPC_W-1:0] OPC_LW   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW   = 6'h2B;

  localparam logic [FUNCT_W-1:0] FN_SLL = 6'h00;
  localparam logic [FUNCT_W-1:0] FN_SRL = 6'h02;
  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/dec_control.sv
module dec_control
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  output ctrlStrobes_t       ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.immKind  = IMM_NONE;
    ctrl.aluOp    = ALU_ADD;
    unique case (opcode)
      OPC_REG: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstRd    = 1'b1;
        case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          FN_SLL:  ctrl.aluOp = ALU_SLL;
          FN_SRL:  ctrl.aluOp = ALU_SRL;
          default: begin
            ctrl.regWrite = 1'b0;
            ctrl.dstRd    = 1'b0;
            ctrl.illegal  = 1'b1;
          end
        endcase
      end
      OPC_ADDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.immKind  = IMM_SIGN;
        ctrl.aluOp    = ALU_ADD;
      end
      OPC_SLTI: begin
        ctrl.regWrite = 1'b1;
        ctrl.immKind  = IMM_SIGN;
        ctrl.aluOp    = ALU_SLT;
      end
      OPC_ANDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.immKind  = IMM_ZERO;
        ctrl.aluOp    = ALU_AND;
      end
      OPC_ORI: begin
        ctrl.regWrite = 1'b1;
        ctrl.immKind  = IMM_ZERO;
        ctrl.aluOp    = ALU_OR;
      end
      OPC_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.immKind  = IMM_UPPER;
        ctrl.aluOp    = ALU_PASSB;
      end
      OPC_LW: begin
        ctrl.regWrite = 1'b1;
        ctrl.memRd    = 1'b1;
        ctrl.immKind  = IMM_SIGN;
      end
      OPC_SW: begin
        ctrl.memWr    = 1'b1;
        ctrl.immKind  = IMM_SIGN;
      end
      OPC_BEQ: begin
        ctrl.brEq     = 1'b1;
        ctrl.immKind  = IMM_SIGN;
        ctrl.aluOp    = ALU_SUB;
      end
      OPC_BNE: begin
        ctrl.brNe     = 1'b1;
        ctrl.immKind  = IMM_SIGN;
        ctrl.aluOp    = ALU_SUB;
      end
      OPC_JMP: ctrl.jmp = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

  // Control-side checks on the strobe bundle
  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      p_one_action_r8: assert ($onehot0({ctrl.memRd, ctrl.memWr, ctrl.brEq, ctrl.brNe, ctrl.jmp}))
        else $error("more than one action strobe");
      if (ctrl.memWr)
        p_store_nowrite_r8: assert (!ctrl.regWrite)
          else $error("store requests a register write");
      if (ctrl.jmp)
        p_jump_quiet_r10: assert (!ctrl.regWrite && ctrl.immKind == IMM_NONE)
          else $error("jump has side effects");
    end
  end

endmodule

// File: rtl/dec_datapath.sv
module dec_datapath
  import instr_dec_pkg::*;
(
  input  logic [TGT_W-1:0]   payload,
  input  ctrlStrobes_t       ctrl,
  output logic [REG_W-1:0]   rsIdx,
  output logic [REG_W-1:0]   rtIdx,
  output logic [SHAMT_W-1:0] shiftAmt,
  output logic [TGT_W-1:0]   jumpTarget,
  output logic [REG_W-1:0]   wrIdx,
  output logic               regWrEn,
  output logic [ALU_W-1:0]   aluOp,
  output logic [INSTR_W-1:0] immValue,
  output logic               memRead,
  output logic               memWrite,
  output logic               branchEq,
  output logic               branchNe,
  output logic               jump,
  output logic               illegal
);

  localparam int EXT_W = INSTR_W - IMM_W;

  logic [REG_W-1:0] rdField;
  logic [IMM_W-1:0] immField;
  logic             active;

  assign rsIdx      = payload[RS_LSB +: REG_W];
  assign rtIdx      = payload[RT_LSB +: REG_W];
  assign rdField    = payload[RD_LSB +: REG_W];
  assign shiftAmt   = payload[SH_LSB +: SHAMT_W];
  assign immField   = payload[IMM_W-1:0];
  assign jumpTarget = payload;

  assign active = !ctrl.illegal;

  always_comb begin
    unique case (ctrl.immKind)
      IMM_SIGN:  immValue = {{EXT_W{immField[IMM_W-1]}}, immField};
      IMM_ZERO:  immValue = {{EXT_W{1'b0}}, immField};
      IMM_UPPER: immValue = {immField, {EXT_W{1'b0}}};
      default:   immValue = '0;
    endcase
  end

  always_comb begin
    if (ctrl.regWrite && active)
      wrIdx = ctrl.dstRd ? rdField : rtIdx;
    else
      wrIdx = '0;
  end

  assign regWrEn  = ctrl.regWrite && active && (wrIdx != '0);
  assign aluOp    = ctrl.aluOp;
  assign memRead  = ctrl.memRd && active;
  assign memWrite = ctrl.memWr && active;
  assign branchEq = ctrl.brEq && active;
  assign branchNe = ctrl.brNe && active;
  assign jump     = ctrl.jmp && active;
  assign illegal  = ctrl.illegal;

  // Output-side checks
  always_comb begin
    if (!$isunknown(payload) && !$isunknown(ctrl)) begin
      if (regWrEn)
        p_zero_dest_r4: assert (wrIdx != '0)
          else $error("write enabled toward index 0");
      if (illegal)
        p_illegal_quiet_r11: assert (!regWrEn && !memRead && !memWrite && !branchEq && !branchNe && !jump)
          else $error("illegal word has side effects");
      if (ctrl.immKind == IMM_UPPER)
        p_upper_low_clear_r7: assert (immValue[EXT_W-1:0] == '0 && immValue[INSTR_W-1:EXT_W] == payload[IMM_W-1:0])
          else $error("upper immediate misplaced");
      if (illegal || jump)
        p_no_imm_r12: assert (immValue == '0)
          else $error("immediate not cleared");
    end
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
(
  input  logic [31:0] instrWord,
  output logic [4:0]  rsIdx,
  output logic [4:0]  rtIdx,
  output logic [4:0]  shiftAmt,
  output logic [25:0] jumpTarget,
  output logic [4:0]  wrIdx,
  output logic        regWrEn,
  output logic [3:0]  aluOp,
  output logic [31:0] immValue,
  output logic        memRead,
  output logic        memWrite,
  output logic        branchEq,
  output logic        branchNe,
  output logic        jump,
  output logic        illegal
);

  ctrlStrobes_t ctrl;

  dec_control u_control (
    .opcode (instrWord[INSTR_W-1 -: OPC_W]),
    .funct  (instrWord[FUNCT_W-1:0]),
    .ctrl   (ctrl)
  );

  dec_datapath u_datapath (
    .payload    (instrWord[TGT_W-1:0]),
    .ctrl       (ctrl),
    .rsIdx      (rsIdx),
    .rtIdx      (rtIdx),
    .shiftAmt   (shiftAmt),
    .jumpTarget (jumpTarget),
    .wrIdx      (wrIdx),
    .regWrEn    (regWrEn),
    .aluOp      (aluOp),
    .immValue   (immValue),
    .memRead    (memRead),
    .memWrite   (memWrite),
    .branchEq   (branchEq),
    .branchNe   (branchNe),
    .jump       (jump),
    .illegal    (illegal)
  );

endmodule

// File: tb/instr_decoder_test.sv
`timescale 1ns/1ps
module instr_decoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instrWord = '0;
  logic [4:0]  rsIdx, rtIdx, shiftAmt, wrIdx;
  logic [25:0] jumpTarget;
  logic        regWrEn, memRead, memWrite, branchEq, branchNe, jump, illegal;
  logic [3:0]  aluOp;
  logic [31:0] immValue;

  instr_decoder uut (
    .instrWord(instrWord), .rsIdx(rsIdx), .rtIdx(rtIdx), .shiftAmt(shiftAmt),
    .jumpTarget(jumpTarget), .wrIdx(wrIdx), .regWrEn(regWrEn), .aluOp(aluOp),
    .immValue(immValue), .memRead(memRead), .memWrite(memWrite),
    .branchEq(branchEq), .branchNe(branchNe), .jump(jump), .illegal(illegal)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected-value model
  logic [3:0]  eAlu;
  logic [31:0] eImm;
  logic [4:0]  eWr;
  logic        eWe, eMr, eMw, eBe, eBn, eJ, eIll;
  string       immReq;

  task automatic model(input logic [31:0] w);
    logic [5:0] op;
    logic [5:0] fn;
    logic       wrRd, wrRt;
    logic [1:0] immK; // 0 none, 1 sign, 2 zero, 3 upper
    op = w[31:26]; fn = w[5:0];
    eAlu = 4'd0; eMr = 0; eMw = 0; eBe = 0; eBn = 0; eJ = 0; eIll = 0;
    wrRd = 0; wrRt = 0; immK = 2'd0;
    case (op)
      6'h00: begin
        wrRd = 1;
        case (fn)
          6'h20: eAlu = 4'd0;
          6'h22: eAlu = 4'd1;
          6'h24: eAlu = 4'd2;
          6'h25: eAlu = 4'd3;
          6'h2A: eAlu = 4'd4;
          6'h00: eAlu = 4'd5;
          6'h02: eAlu = 4'd6;
          default: begin wrRd = 0; eIll = 1; end
        endcase
      end
      6'h08: begin wrRt = 1; immK = 1; eAlu = 4'd0; end
      6'h0A: begin wrRt = 1; immK = 1; eAlu = 4'd4; end
      6'h0C: begin wrRt = 1; immK = 2; eAlu = 4'd2; end
      6'h0D: begin wrRt = 1; immK = 2; eAlu = 4'd3; end
      6'h0F: begin wrRt = 1; immK = 3; eAlu = 4'd7; end
      6'h23: begin wrRt = 1; immK = 1; eMr = 1; end
      6'h2B: begin immK = 1; eMw = 1; end
      6'h04: begin immK = 1; eBe = 1; eAlu = 4'd1; end
      6'h05: begin immK = 1; eBn = 1; eAlu = 4'd1; end
      6'h02: eJ = 1;
      default: eIll = 1;
    endcase
    eWr = wrRd ? w[15:11] : (wrRt ? w[20:16] : 5'd0);
    eWe = (wrRd || wrRt) && (eWr != 0);
    case (immK)
      2'd1: begin eImm = 32'(signed'(w[15:0])); immReq = "R5"; end
      2'd2: begin eImm = {16'h0, w[15:0]}; immReq = "R6"; end
      2'd3: begin eImm = {w[15:0], 16'h0}; immReq = "R7"; end
      default: begin eImm = 32'h0; immReq = "R12"; end
    endcase
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    #1 instrWord = w;
    #2;
  endtask

  task automatic checkAll(input logic [31:0] w);
    apply(w);
    model(w);
    chk("R1", "rsIdx", 32'(rsIdx), 32'(w[25:21]));
    chk("R1", "rtIdx", 32'(rtIdx), 32'(w[20:16]));
    chk("R1", "shiftAmt", 32'(shiftAmt), 32'(w[10:6]));
    chk("R1", "jumpTarget", 32'(jumpTarget), 32'(w[25:0]));
    chk(w[31:26] == 6'h00 ? "R2" : "R13", "aluOp", 32'(aluOp), 32'(eAlu));
    chk("R3", "wrIdx", 32'(wrIdx), 32'(eWr));
    chk("R4", "regWrEn", 32'(regWrEn), 32'(eWe));
    chk(immReq, "immValue", immValue, eImm);
    chk("R8", "memRead/memWrite", 32'({memRead, memWrite}), 32'({eMr, eMw}));
    chk("R9", "branchEq/branchNe", 32'({branchEq, branchNe}), 32'({eBe, eBn}));
    chk("R10", "jump", 32'(jump), 32'(eJ));
    chk("R11", "illegal", 32'(illegal), 32'(eIll));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [25:0] lfsr;
    lfsr = 26'h2A5F31C;
    repeat (3) @(posedge clk);
    #3;
    // Reset state: word 0 decodes as a shift toward index 0, no write
    chk("R4", "reset regWrEn", 32'(regWrEn), 32'h0);
    chk("R11", "reset illegal", 32'(illegal), 32'h0);
    rstN = 1'b1;

    // Directed corner cases
    checkAll(32'h3C01ABCD); // lui R7
    chk("R7", "lui value", immValue, 32'hABCD0000);
    checkAll(32'h2002FFFF); // addi -1 R5
    chk("R5", "addi -1", immValue, 32'hFFFFFFFF);
    checkAll(32'h34038000); // ori R6
    chk("R6", "ori 0x8000", immValue, 32'h00008000);
    checkAll(32'h00000020); // add to index 0 R4
    chk("R4", "add r0 suppressed", 32'(regWrEn), 32'h0);
    checkAll(32'hAC220010); // sw R8
    chk("R8", "sw no write", 32'(regWrEn), 32'h0);
    checkAll(32'h08000123); // j R10
    chk("R10", "jump flag", 32'(jump), 32'h1);
    checkAll(32'hFC000000); // illegal opcode R11
    chk("R11", "illegal opcode", 32'(illegal), 32'h1);
    checkAll(32'h012A5821); // unlisted funct R11
    chk("R11", "illegal funct write", 32'(regWrEn), 32'h0);

    // Sweep of every opcode with several field patterns
    for (int op = 0; op < 64; op++) begin
      for (int p = 0; p < 4; p++) begin
        logic [25:0] body;
        case (p)
          0: body = 26'h0;
          1: body = 26'h3FFFFFF;
          2: body = 26'h0218000;
          default: begin
            lfsr = {lfsr[24:0], lfsr[25] ^ lfsr[5] ^ lfsr[1] ^ lfsr[0]};
            body = lfsr;
          end
        endcase
        checkAll({op[5:0], body});
      end
    end

    // Sweep of every function code under the register opcode
    for (int fn = 0; fn < 64; fn++) begin
      for (int p = 0; p < 4; p++) begin
        logic [19:0] hi;
        case (p)
          0: hi = 20'h0;
          1: hi = 20'hFFFFF;
          2: hi = 20'h4A5C3;
          default: begin
            lfsr = {lfsr[24:0], lfsr[25] ^ lfsr[5] ^ lfsr[1] ^ lfsr[0]};
            hi = lfsr[19:0];
          end
        endcase
        checkAll({6'h00, hi, fn[5:0]});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule